// File: doc/BRIEF.md
# Paging Frame Address and Vector Parser

This block sits behind the deinterleaver and error corrector of a paging receiver. It takes the 88 words of one frame in order, 11 blocks of 8, each word tagged with its position 0 to 87. Word 0 is the block information word. From it the block learns where the address list begins and where the vector area starts. It also captures the frame collapse and carry-on values. Any extended information words between word 0 and the first address are passed over.

Each word in the address area is a short address, and the block stores its 17-bit data field. The vector area starts at the position given by the information word. The vector at offset k from that start belongs to the k-th address. When a vector arrives, the block emits one record with the stored address, the vector type, the message start and the message length. An information word whose vector start is not usable flags the frame as bad and suppresses all records until the next information word.

Bit k of `word_data` is the k-th transmitted bit of the word. A multi-bit field takes its lowest-numbered bit as its least significant bit. Checksum bits 3:0, CRC bits 30:21 and parity bit 31 are not used.

Top module: `frame_vec_parser`

## Requirements
- R1: After reset, `rec_valid`, `frame_err`, `frame_collapse` and `frame_carry` are all 0.
- R2: One cycle after an accepted word at position 0, `frame_collapse` equals bits 20:18 of that word and `frame_carry` equals bits 17:16. Both hold their values until the next word at position 0.
- R3: Bits 9:8 of the information word give E, and the first address is at position E+1. Words at positions 1 to E are skipped: they are never reported as addresses.
- R4: Bits 15:10 of the information word give the vector start S. Words at positions E+1 to S-1 are addresses. The vector at position S+k is paired with the address at position E+1+k.
- R5: A record carries these fields. `rec_addr` is bits 20:4 of the paired address word. `rec_vtype` is bits 6:4 of the vector word, with codes 0 secure, 1 short instruction, 2 short message, 3 numeric, 4 numeric with format, 5 alphanumeric and 6 hex/binary. `rec_mstart` is bits 13:7 and `rec_mlen` is bits 20:14.
- R6: Each vector word yields exactly one record, with `rec_valid` high for one cycle, one cycle after the word is accepted. Address words, skipped words and words at positions S+(S-E-1) or later yield no record.
- R7: `frame_err` rises one cycle after an information word whose S is not greater than E+1, or whose S exceeds 87. While `frame_err` is set, no record is produced.
- R8: A new word at position 0 restarts parsing: it replaces S, E, collapse and carry-on, and it clears `frame_err` when its fields are valid.
- R9: A word presented while `word_valid` is low has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | Word strobe |
| word_pos | input | 7 | Word position in frame, 0..87 |
| word_data | input | 32 | Corrected word, bit 0 transmitted first |
| rec_valid | output | 1 | Record strobe |
| rec_addr | output | 17 | Address data field |
| rec_vtype | output | 3 | Vector type code |
| rec_mstart | output | 7 | Message start word |
| rec_mlen | output | 7 | Message length |
| frame_err | output | 1 | Information word layout invalid |
| frame_collapse | output | 3 | Collapse exponent n (1 frame in 2^n) |
| frame_carry | output | 2 | Carry-on value |

## Verification
Suppose E or S is latched wrongly. Then the very first vector word shows it: `rec_addr` carries an extended word's data or a neighbouring address, or the record appears one position early or late. A wrong pairing index shows at the first record whose address is not the first address. A stale error flag shows one cycle after the next vector word, as a missing or extra `rec_valid` pulse. The tests use frames with and without extended words, gaps in `word_valid`, words beyond the vector area, and invalid layouts followed by a valid one.

// File: rtl/fvp_pkg.sv
package fvp_pkg;
  localparam int WORD_W  = 32;
  localparam int FIELD_W = 17;

  typedef struct packed {
    logic [2:0] vtype;
    logic [6:0] mstart;
    logic [6:0] mlen;
  } vec_t;

  function automatic vec_t get_vec(input logic [FIELD_W-1:0] f);
    vec_t v;
    v.vtype  = f[2:0];
    v.mstart = f[9:3];
    v.mlen   = f[16:10];
    return v;
  endfunction
endpackage

// File: rtl/fvp_biw_decode.sv
module fvp_biw_decode #(
  parameter int POS_W    = 7,
  parameter int LAST_POS = 87
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [16:0]      field,
  output logic             have,
  output logic [POS_W:0]   first_pos,
  output logic [POS_W:0]   vstart,
  output logic             err,
  output logic [2:0]       collapse,
  output logic [1:0]       carry
);
  logic [POS_W:0] first_n, vs_n;
  logic [3:0]     prio_unused;

  assign prio_unused = field[3:0];
  assign first_n = (POS_W+1)'(field[5:4]) + (POS_W+1)'(1);
  assign vs_n    = (POS_W+1)'(field[11:6]);

  always_ff @(posedge clk) begin
    if (rst) begin
      have      <= 1'b0;
      first_pos <= '0;
      vstart    <= '0;
      err       <= 1'b0;
      collapse  <= '0;
      carry     <= '0;
    end else if (load) begin
      have      <= 1'b1;
      first_pos <= first_n;
      vstart    <= vs_n;
      err       <= (vs_n <= first_n) || (vs_n > (POS_W+1)'(LAST_POS));
      carry     <= field[13:12];
      collapse  <= field[16:14];
    end
  end

  AST_ERR_ONLY_AT_BIW: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> $past(load)); // R7
  AST_COLLAPSE_HELD: assert property (@(posedge clk) disable iff (rst)
    !$past(load) |-> ($stable(collapse) && $stable(carry))); // R2
endmodule

// File: rtl/fvp_addr_store.sv
module fvp_addr_store #(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6,
  parameter int DW    = 17
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/frame_vec_parser.sv
module frame_vec_parser
  import fvp_pkg::*;
#(
  parameter int POS_W      = 7,
  parameter int LAST_POS   = 87,
  parameter int ADDR_DEPTH = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               word_valid,
  input  logic [POS_W-1:0]   word_pos,
  input  logic [WORD_W-1:0]  word_data,
  output logic               rec_valid,
  output logic [FIELD_W-1:0] rec_addr,
  output logic [2:0]         rec_vtype,
  output logic [6:0]         rec_mstart,
  output logic [6:0]         rec_mlen,
  output logic               frame_err,
  output logic [2:0]         frame_collapse,
  output logic [1:0]         frame_carry
);
  localparam int AIDX_W = $clog2(ADDR_DEPTH);

  logic [FIELD_W-1:0] field;
  logic               unused_bits;
  logic               biw_hit, have, live, is_addr, is_vec;
  logic [POS_W:0]     pos_x, first_x, vs_x, naddr, vec_end, wdiff, rdiff;
  vec_t               vec;

  assign field       = word_data[20:4];
  assign unused_bits = ^{word_data[3:0], word_data[31:21]};
  assign biw_hit     = word_valid && (word_pos == '0);

  fvp_biw_decode #(.POS_W(POS_W), .LAST_POS(LAST_POS)) u_biw (
    .clk(clk), .rst(rst), .load(biw_hit), .field(field),
    .have(have), .first_pos(first_x), .vstart(vs_x), .err(frame_err),
    .collapse(frame_collapse), .carry(frame_carry)
  );

  assign pos_x   = {1'b0, word_pos};
  assign naddr   = vs_x - first_x;
  assign vec_end = vs_x + naddr;
  assign wdiff   = pos_x - first_x;
  assign rdiff   = pos_x - vs_x;
  assign live    = word_valid && have && !frame_err;
  assign is_addr = live && (pos_x >= first_x) && (pos_x < vs_x);
  assign is_vec  = live && (pos_x >= vs_x) && (pos_x < vec_end);
  assign vec     = get_vec(field);

  fvp_addr_store #(.DEPTH(ADDR_DEPTH), .IDX_W(AIDX_W), .DW(FIELD_W)) u_store (
    .clk(clk), .we(is_addr), .waddr(wdiff[AIDX_W-1:0]), .wdata(field),
    .re(is_vec), .raddr(rdiff[AIDX_W-1:0]), .rdata(rec_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_valid  <= 1'b0;
      rec_vtype  <= '0;
      rec_mstart <= '0;
      rec_mlen   <= '0;
    end else begin
      rec_valid <= is_vec;
      if (is_vec) begin
        rec_vtype  <= vec.vtype;
        rec_mstart <= vec.mstart;
        rec_mlen   <= vec.mlen;
      end
    end
  end

  AST_REC_FROM_WORD: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> $past(word_valid)); // R6
  AST_NO_REC_UNDER_ERR: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> !$past(frame_err)); // R7
  AST_NO_REC_FOR_BIW: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> ($past(word_pos) != '0)); // R6
  AST_SINGLE_PULSE_ON_GAP: assert property (@(posedge clk) disable iff (rst)
    !$past(word_valid) |-> !rec_valid); // R9
endmodule

// File: tb/test_frame_vec_parser.sv
module test_frame_vec_parser;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_valid = 1'b0;
  logic [6:0]  word_pos = '0;
  logic [31:0] word_data = '0;
  logic        rec_valid, frame_err;
  logic [16:0] rec_addr;
  logic [2:0]  rec_vtype, frame_collapse;
  logic [6:0]  rec_mstart, rec_mlen;
  logic [1:0]  frame_carry;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  frame_vec_parser i_frame_vec_parser (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_pos(word_pos),
    .word_data(word_data), .rec_valid(rec_valid), .rec_addr(rec_addr),
    .rec_vtype(rec_vtype), .rec_mstart(rec_mstart), .rec_mlen(rec_mlen),
    .frame_err(frame_err), .frame_collapse(frame_collapse), .frame_carry(frame_carry)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wrap(input logic [16:0] d);
    return {11'h6B5, d, 4'hA};
  endfunction

  function automatic logic [31:0] mk_biw(input logic [1:0] eob, input logic [5:0] vs,
                                         input logic [1:0] cr, input logic [2:0] co);
    return wrap({co, cr, vs, eob, 4'h9});
  endfunction

  function automatic logic [31:0] mk_vec(input logic [2:0] t, input logic [6:0] s,
                                         input logic [6:0] l);
    return wrap({l, s, t});
  endfunction

  task automatic put(input int pos, input logic [31:0] d);
    @(negedge clk);
    word_valid = 1'b1;
    word_pos   = 7'(pos);
    word_data  = d;
    @(negedge clk);
    word_valid = 1'b0;
    word_data  = 32'hFFFF_FFFF;
  endtask

  task automatic chk_rec(input logic [16:0] a, input logic [2:0] t, input logic [6:0] s,
                         input logic [6:0] l);
    chk(rec_valid == 1'b1, "R6 record strobe", rec_valid, 1);
    chk(rec_addr == a, "R4 paired address", rec_addr, a);
    chk(rec_vtype == t && rec_mstart == s && rec_mlen == l, "R5 vector fields",
        {rec_vtype, rec_mstart, rec_mlen}, {t, s, l});
  endtask

  task automatic t_reset;
    chk(rec_valid == 0 && frame_err == 0, "R1 reset strobes", {rec_valid, frame_err}, 0);
    chk(frame_collapse == 0 && frame_carry == 0, "R1 reset fields",
        {frame_collapse, frame_carry}, 0);
  endtask

  task automatic t_basic;
    put(0, mk_biw(2'd0, 6'd4, 2'd2, 3'd5));
    chk(frame_collapse == 5, "R2 collapse", frame_collapse, 5);
    chk(frame_carry == 2, "R2 carry", frame_carry, 2);
    chk(frame_err == 0, "R7 valid layout", frame_err, 0);
    put(1, wrap(17'h1_2345)); chk(rec_valid == 0, "R6 address no record", rec_valid, 0);
    put(2, wrap(17'h0_0F0F));
    put(3, wrap(17'h1_FFFE));
    put(4, mk_vec(3'd5, 7'd10, 7'd3)); chk_rec(17'h1_2345, 3'd5, 7'd10, 7'd3);
    put(5, mk_vec(3'd1, 7'd13, 7'd1)); chk_rec(17'h0_0F0F, 3'd1, 7'd13, 7'd1);
    put(6, mk_vec(3'd6, 7'd14, 7'd9)); chk_rec(17'h1_FFFE, 3'd6, 7'd14, 7'd9);
    put(7, mk_vec(3'd2, 7'd1, 7'd1));
    chk(rec_valid == 0, "R6 beyond vector area", rec_valid, 1'b0);
    chk(frame_collapse == 5 && frame_carry == 2, "R2 held", {frame_collapse, frame_carry}, 8'h16);
  endtask

  task automatic t_extended;
    put(0, mk_biw(2'd2, 6'd5, 2'd1, 3'd7));
    chk(frame_collapse == 7 && frame_carry == 1, "R8 refreshed fields",
        {frame_collapse, frame_carry}, 8'h1D);
    put(1, wrap(17'h0_AAAA)); chk(rec_valid == 0, "R3 extended no record", rec_valid, 0);
    put(2, wrap(17'h0_BBBB));
    put(3, wrap(17'h1_0001));
    put(4, wrap(17'h1_0002));
    put(5, mk_vec(3'd0, 7'd7, 7'd2)); chk_rec(17'h1_0001, 3'd0, 7'd7, 7'd2); // R3
    @(negedge clk);
    word_valid = 1'b0; word_pos = 7'd6; word_data = mk_vec(3'd3, 7'd9, 7'd9);
    @(negedge clk);
    chk(rec_valid == 0, "R9 invalid word ignored", rec_valid, 0);
    put(6, mk_vec(3'd4, 7'd9, 7'd5)); chk_rec(17'h1_0002, 3'd4, 7'd9, 7'd5);
  endtask

  task automatic t_error;
    put(0, mk_biw(2'd0, 6'd1, 2'd0, 3'd0));
    chk(frame_err == 1, "R7 start equals first address", frame_err, 1);
    put(1, mk_vec(3'd5, 7'd1, 7'd1));
    chk(rec_valid == 0, "R7 no record under error", rec_valid, 0);
    put(0, mk_biw(2'd3, 6'd3, 2'd0, 3'd0));
    chk(frame_err == 1, "R7 start below first address", frame_err, 1);
    put(3, mk_vec(3'd5, 7'd1, 7'd1));
    chk(rec_valid == 0, "R7 no record under error", rec_valid, 0);
    put(0, mk_biw(2'd1, 6'd3, 2'd3, 3'd1));
    chk(frame_err == 0, "R8 error cleared", frame_err, 0);
    put(2, wrap(17'h0_5A5A));
    put(3, mk_vec(3'd5, 7'd40, 7'd20)); chk_rec(17'h0_5A5A, 3'd5, 7'd40, 7'd20); // R8
    put(4, mk_vec(3'd5, 7'd40, 7'd20));
    chk(rec_valid == 0, "R6 single vector only", rec_valid, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_basic;
    t_extended;
    t_error;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule